// File: doc/BRIEF.md
# Multi-Mode 16-bit Down Timer

This block is a programmable down-counting timer with a 16-bit counter. A small register write port holds one control byte and the two bytes of a reload value. When the run bit is set, the counter loads the reload value. It then decrements once per prescaler tick. The counter drives one output pin in one of four waveform modes: a single pulse, a periodic rate pulse, a square wave, or a retriggerable one-shot started by a trigger input.

A prescaler divides its event source by 1, 4, 16 or 64. The source is either the system clock or the rising edges of an external clock pin, which is synchronized into the system clock domain. The level of the output pin is programmable. Reaching terminal count can raise a sticky interrupt line. A reload value of zero behaves as 65536 ticks. The live count is visible on an output port so software or a neighbouring block can sample it.

Top module: `pulse_down_timer`

## Requirements
- R1: After reset the control byte, reload value and count are zero, `irq` is 0 and `tmr_out` is 1. A write with `wr_en` high stores `wr_data` into the control byte at address 0, the reload low byte at address 1 or the reload high byte at address 2.
- R2: The control byte bit 0 is the run bit. Its 0-to-1 change loads the counter from the reload value on the next clock edge. Clearing it stops the timer.
- R3: While the run bit is 0 the count holds its value and `tmr_out` is at its inactive level.
- R4: Control bits 5:4 select the prescaler divisor: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. The counter decrements once per divided event, and the prescaler restarts from zero on every load.
- R5: Control bit 6 set makes the prescaler count rising edges of `ext_clk`, synchronized through two flops, instead of system clock cycles. The system clock alone then does not decrement the count.
- R6: Mode 00 (control bits 3:2) is the single pulse. The output goes active in the cycle after the run bit is set and stays active for exactly N × divisor system clock cycles with the internal source. It then goes inactive and the count rests at 0.
- R7: Mode 01 is the rate mode. The output is active for one system clock cycle every N ticks, and the counter reloads on each terminal count.
- R8: Mode 10 is the square wave. The output starts inactive and toggles every N ticks, and the counter reloads on each terminal count.
- R9: Mode 11 is the retriggerable one-shot. The output stays inactive until a synchronized rising edge of `trig_in` loads the counter and makes it active. A further edge while active reloads and extends the pulse. In every other mode `trig_in` has no effect.
- R10: Control bit 1 set makes the active output level 1. Cleared, the active level is 0.
- R11: When control bit 7 is set, terminal count sets `irq`, and any write to the control byte clears it. With bit 7 clear, `irq` stays 0.
- R12: Writing the reload bytes while a pulse runs does not change that pulse. The new value is used at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 reload low, 2 reload high |
| wr_data | input | 8 | Write data |
| ext_clk | input | 1 | External count source, asynchronous |
| trig_in | input | 1 | One-shot trigger, asynchronous |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Terminal-count interrupt, sticky |
| count | output | 16 | Current counter value |

## Verification
The bound checker watches the parts that hold from cycle to cycle. It confirms that the count never moves while stopped and that the prescaler never ticks while stopped. It confirms that the single-pulse counter only steps by one, that a qualified trigger edge always reloads and activates the one-shot, and that the interrupt can only rise with its enable set. Whole waveforms can only be judged by the bench scenarios that measure them at the pin. Those waveforms are the pulse width for each divisor, the rate period, the square-wave half periods, the extension of a retriggered pulse, the external-edge counting, the polarity, and the late reload write that must not disturb a running pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_PULSE  = 2'd0,
        MODE_RATE   = 2'd1,
        MODE_WAVE   = 2'd2,
        MODE_RETRIG = 2'd3
    } tmode_e;

    localparam int PSEL_W = 2;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic              ie;
        logic              ext_src;
        logic [PSEL_W-1:0] psel;
        tmode_e            mode;
        logic              pol;
        logic              run;
    } tctrl_t;

    localparam int CTRL_W = $bits(tctrl_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    localparam int SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the last synchronizer stage is high and the history stage is still low
    assign rise = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             ev,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int NSEL  = 1 << SEL_W;
    localparam int PRE_W = 2 * (NSEL - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] mask_tab [NSEL];
    logic [PRE_W-1:0] mask;

    // divisor for select i is 4**i: a tick whenever the low 2*i bits are all ones
    generate
        for (genvar i = 0; i < NSEL; i++) begin : g_mask
            assign mask_tab[i] = PRE_W'((64'd1 << (2 * i)) - 64'd1);
        end
    endgenerate

    assign mask = mask_tab[sel];
    assign tick = en & ev & ~clr & ((st_q.pre & mask) == mask);

    always_comb begin
        st_d = st_q;
        if (clr)           st_d.pre = '0;
        else if (en && ev) st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tmode_e           mode,
    input  logic             tick,
    input  logic             trig_rise,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             tc,
    output logic             pre_clr
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             run_prev;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     start;
    logic     retrig;
    logic     at_one;

    assign start  = run & ~st_q.run_prev;
    assign retrig = run & ~start & (mode == MODE_RETRIG) & trig_rise;
    assign at_one = (st_q.cnt == CNT_W'(1));

    always_comb begin
        st_d          = st_q;
        st_d.run_prev = run;
        tc            = 1'b0;
        if (!run) begin
            st_d.active = 1'b0;
        end else if (start) begin
            st_d.cnt    = load_val;
            st_d.active = (mode == MODE_PULSE);
        end else if (retrig) begin
            st_d.cnt    = load_val;
            st_d.active = 1'b1;
        end else begin
            if (mode == MODE_RATE) st_d.active = 1'b0;
            if (tick) begin
                unique case (mode)
                    MODE_PULSE, MODE_RETRIG: begin
                        if (st_q.active) begin
                            if (at_one) begin
                                st_d.cnt    = '0;
                                st_d.active = 1'b0;
                                tc          = 1'b1;
                            end else begin
                                st_d.cnt = st_q.cnt - 1'b1;
                            end
                        end
                    end
                    MODE_RATE: begin
                        if (at_one) begin
                            st_d.cnt    = load_val;
                            st_d.active = 1'b1;
                            tc          = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                    default: begin
                        if (at_one) begin
                            st_d.cnt    = load_val;
                            st_d.active = ~st_q.active;
                            tc          = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign active  = st_q.active;
    assign pre_clr = start | retrig;

endmodule

// File: rtl/pulse_down_timer.sv
module pulse_down_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  ext_clk,
    input  logic                  trig_in,
    output logic                  tmr_out,
    output logic                  irq,
    output logic [2*DATA_W-1:0]   count
);

    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        tctrl_t            ctrl;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic              irq;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             ext_rise;
    logic             trig_rise;
    logic             src_ev;
    logic             tick;
    logic             tc;
    logic             pre_clr;
    logic             core_active;
    logic [CNT_W-1:0] load_val;
    logic             ctrl_wr;

    assign load_val = {st_q.hi, st_q.lo};
    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: st_d.ctrl = tctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_LO:   st_d.lo   = wr_data;
                ADDR_HI:   st_d.hi   = wr_data;
                default:   ;
            endcase
        end
        if (ctrl_wr)              st_d.irq = 1'b0;
        if (tc && st_q.ctrl.ie)   st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_clk),
        .rise (ext_rise)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_in),
        .rise (trig_rise)
    );

    assign src_ev = st_q.ctrl.ext_src ? ext_rise : 1'b1;

    tmr_prescale #(.SEL_W(PSEL_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pre_clr),
        .en   (st_q.ctrl.run),
        .ev   (src_ev),
        .sel  (st_q.ctrl.psel),
        .tick (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.ctrl.run),
        .mode     (st_q.ctrl.mode),
        .tick     (tick),
        .trig_rise(trig_rise),
        .load_val (load_val),
        .cnt      (count),
        .active   (core_active),
        .tc       (tc),
        .pre_clr  (pre_clr)
    );

    // gated by run so the pin is inactive in the same cycle the timer stops
    assign tmr_out = (st_q.ctrl.run && core_active) ? st_q.ctrl.pol : ~st_q.ctrl.pol;
    assign irq     = st_q.irq;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [1:0]       mode,
    input logic             ie,
    input logic             trig_rise,
    input logic             tick,
    input logic             active,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load,
    input logic             irq
);

    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));

    p_no_tick_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    p_pulse_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && mode == MODE_PULSE) |=>
        (count == $past(count) || count == CNT_W'($past(count) - 1'b1)));

    p_retrig_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && mode == MODE_RETRIG && trig_rise) |=>
        (active && count == $past(load)));

    p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ie));

endmodule

bind pulse_down_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q.ctrl.run),
    .mode     (st_q.ctrl.mode),
    .ie       (st_q.ctrl.ie),
    .trig_rise(trig_rise),
    .tick     (tick),
    .active   (core_active),
    .count    (count),
    .load     (load_val),
    .irq      (irq)
);

// File: tb/sim_pulse_down_timer.sv
`timescale 1ns/1ps
module sim_pulse_down_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        ext_clk = 1'b0;
    logic        trig_in = 1'b0;
    logic        tmr_out;
    logic        irq;
    logic [15:0] count;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    int w1, w2;

    always #2.5 clk = ~clk;

    pulse_down_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_clk(ext_clk), .trig_in(trig_in), .tmr_out(tmr_out), .irq(irq), .count(count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] cw(input bit ie, input bit ext, input int ps,
                                      input int md, input bit pol, input bit run);
        return {ie, ext, 2'(ps), 2'(md), pol, run};
    endfunction

    function automatic int exp_width(input int n, input int ps);
        return n * (1 << (2 * ps));
    endfunction

    task automatic set_count(input int n);
        wr(2'd1, 8'(n));
        wr(2'd2, 8'(n >> 8));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for the active level, then counts cycles spent at it
    task automatic measure(input bit lvl, input int limit, output int w);
        int t = 0;
        w = 0;
        while (tmr_out !== lvl && t < limit) begin @(negedge clk); t++; end
        while (tmr_out === lvl && w < limit) begin w++; @(negedge clk); end
    endtask

    task automatic count_level(input bit lvl, input int limit, output int w);
        w = 0;
        while (tmr_out === lvl && w < limit) begin w++; @(negedge clk); end
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig_in = 1'b1;
        idle(3);
        trig_in = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_clk = 1'b1;
        idle(4);
        ext_clk = 1'b0;
        idle(4);
    endtask

    task automatic stop_timer(input bit pol);
        wr(2'd0, cw(0, 0, 0, 0, pol, 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int c;
        void'($urandom(32'd1357));
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        chk(tmr_out === 1'b1, "R1 out after reset", tmr_out, 1);
        chk(irq === 1'b0, "R1 irq after reset", irq, 0);
        chk(count === 16'd0, "R1 count after reset", count, 0);

        // R6 + R2: single pulse, divide by 1
        set_count(12);
        wr(2'd0, cw(0, 0, 0, 0, 1, 1));
        measure(1'b1, 5000, w1);
        chk(w1 == 12, "R6 single pulse width", w1, 12);
        chk(count === 16'd0, "R6 count rests at zero", count, 0);
        stop_timer(1);

        // R10: active-low polarity
        set_count(7);
        wr(2'd0, cw(0, 0, 0, 0, 0, 1));
        measure(1'b0, 5000, w1);
        chk(w1 == 7, "R10 active-low width", w1, 7);
        stop_timer(0);
        idle(1);
        chk(tmr_out === 1'b1, "R10 inactive high when stopped", tmr_out, 1);

        // R3: hold while stopped
        set_count(200);
        wr(2'd0, cw(0, 0, 0, 0, 1, 1));
        idle(10);
        stop_timer(1);
        idle(2);
        c = count;
        idle(20);
        chk(count == c, "R3 count holds when stopped", count, c);
        chk(c < 200 && c > 150, "R2 count decremented while running", c, 190);
        chk(tmr_out === 1'b0, "R3 output inactive when stopped", tmr_out, 0);

        // R7: rate mode, N=6 divide by 4 -> period 24
        set_count(6);
        wr(2'd0, cw(0, 0, 1, 1, 1, 1));
        measure(1'b1, 5000, w1);
        chk(w1 == 1, "R7 rate pulse width", w1, 1);
        count_level(1'b0, 5000, w2);
        chk(w2 + 1 == 24, "R7 rate period", w2 + 1, 24);
        stop_timer(1);

        // R8: square wave, N=5 divide by 1
        set_count(5);
        wr(2'd0, cw(0, 0, 0, 2, 1, 1));
        measure(1'b1, 5000, w1);
        chk(w1 == 5, "R8 square high half", w1, 5);
        count_level(1'b0, 5000, w2);
        chk(w2 == 5, "R8 square low half", w2, 5);
        stop_timer(1);

        // R9: one-shot idles until triggered, retrigger extends
        set_count(20);
        wr(2'd0, cw(0, 0, 0, 3, 1, 1));
        idle(5);
        chk(tmr_out === 1'b0, "R9 one-shot idle before trigger", tmr_out, 0);
        fork
            measure(1'b1, 5000, w1);
            begin
                idle(3);
                pulse_trig();
                idle(7);
                pulse_trig();
            end
        join
        chk(w1 == 31, "R9 retriggered width", w1, 31);
        stop_timer(1);

        // R9: trigger has no effect in single-pulse mode
        set_count(20);
        wr(2'd0, cw(0, 0, 0, 0, 1, 1));
        fork
            measure(1'b1, 5000, w1);
            begin idle(5); pulse_trig(); end
        join
        chk(w1 == 20, "R9 trigger ignored in pulse mode", w1, 20);
        stop_timer(1);

        // R5: external source
        set_count(10);
        wr(2'd0, cw(0, 1, 0, 0, 1, 1));
        idle(10);
        chk(count === 16'd10, "R5 internal clock ignored", count, 10);
        chk(tmr_out === 1'b1, "R5 output active", tmr_out, 1);
        ext_pulse(); ext_pulse(); ext_pulse();
        idle(6);
        chk(count === 16'd7, "R5 three external edges", count, 7);
        stop_timer(1);

        // R11: interrupt with enable, cleared by control write
        set_count(3);
        wr(2'd0, cw(1, 0, 0, 0, 1, 1));
        measure(1'b1, 5000, w1);
        idle(2);
        chk(irq === 1'b1, "R11 irq set at terminal count", irq, 1);
        wr(2'd0, cw(1, 0, 0, 0, 1, 1));
        chk(irq === 1'b0, "R11 irq cleared by control write", irq, 0);
        stop_timer(1);
        wr(2'd0, cw(0, 0, 0, 0, 1, 1));
        measure(1'b1, 5000, w1);
        idle(2);
        chk(irq === 1'b0, "R11 irq stays low when disabled", irq, 0);
        stop_timer(1);

        // R12: reload written mid-pulse does not alter it
        set_count(30);
        wr(2'd0, cw(0, 0, 0, 0, 1, 1));
        fork
            measure(1'b1, 5000, w1);
            begin idle(5); wr(2'd1, 8'd3); end
        join
        chk(w1 == 30, "R12 running pulse unchanged", w1, 30);
        stop_timer(1);
        wr(2'd0, cw(0, 0, 0, 0, 1, 1));
        measure(1'b1, 5000, w1);
        chk(w1 == 3, "R12 new value at next load", w1, 3);
        stop_timer(1);

        // R4 with R6/R9/R10: random widths, divisors, polarity
        for (int i = 0; i < 16; i++) begin
            int n  = 1 + int'($urandom % 30);
            int ps = int'($urandom % 4);
            int md = ($urandom % 2) ? 3 : 0;
            bit pl = bit'($urandom % 2);
            int e  = exp_width(n, ps);
            set_count(n);
            wr(2'd0, cw(0, 0, ps, md, pl, 1));
            if (md == 3) begin
                fork
                    measure(pl, 5000, w1);
                    begin idle(2); pulse_trig(); end
                join
            end else begin
                measure(pl, 5000, w1);
            end
            chk(w1 == e, "R4 divided pulse width", w1, e);
            stop_timer(pl);
            idle(1);
            chk(tmr_out === ~pl, "R3 inactive after stop", tmr_out, ~pl);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule